// File: doc/BRIEF.md
# Binary/Decade Up/Down Counter Stage

This block is a single 4-bit counting stage. On each rising clock edge it steps up or down by one. The direction comes from one input. A second input selects the range: either the full binary range of sixteen states or a decimal range of ten states. Both inputs may change at run time, and the next edge uses the new setting. All four count bits come from one register and change on the same edge, so the outputs never ripple.

A parallel preset loads any 4-bit value as soon as the preset enable rises, without waiting for a clock. An active-low carry input enables counting. An active-low carry output marks the last state before a wrap. Stages are chained into wider counters by feeding the carry output of the lower stage into the carry input of the next stage, with all stages on one clock.

A synchronous reset clears the stage to zero.

Top module: `bd_updown_counter`

## Requirements
- R1: Binary range (`mode_bin`=1) counting up: each enabled rising edge adds one modulo 16, so 15 is followed by 0.
- R2: Binary range counting down (`dir_up`=0): each enabled edge subtracts one, so 0 is followed by 15.
- R3: Decimal range (`mode_bin`=0) counting up: values 0 to 8 step to the next value, and any value from 9 to 15 steps to 0.
- R4: Decimal range counting down: 0 steps to 9, and every other value, including 10 to 15, decrements by one.
- R5: While `cy_in_n` is high, rising edges leave the count unchanged. Counting happens only while `cy_in_n` is low.
- R6: `cy_out_n` is low exactly when `cy_in_n` is low and the count is terminal. The terminal value is 15 in binary up, 9 in decimal up, and 0 when counting down in either range.
- R7: A rising `load_en` places `load_val` on `count` at once, with no clock edge. While `load_en` stays high, clock edges do not count. Instead, each edge reloads the current `load_val`, so a change of `load_val` during the hold appears at the next rising edge. Counting resumes on the first rising edge after `load_en` falls.
- R8: `rst` high at a rising edge clears the count to 0. If `load_en` is also high, the preset takes priority.
- R9: Two stages on one clock, with the lower stage's `cy_out_n` driving the upper stage's `cy_in_n`, count as one two-digit counter in either range and either direction.
- R10: A change of `mode_bin` or `dir_up` between edges takes effect on the very next enabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counting clock, rising edge active |
| rst | input | 1 | Synchronous reset to zero, active high |
| load_en | input | 1 | Asynchronous parallel preset enable, active high |
| load_val | input | 4 | Preset value |
| dir_up | input | 1 | 1 = count up, 0 = count down |
| mode_bin | input | 1 | 1 = binary range 0..15, 0 = decimal range 0..9 |
| cy_in_n | input | 1 | Count enable from the lower stage, active low |
| count | output | 4 | Current count |
| cy_out_n | output | 1 | Terminal-count carry to the next stage, active low |

## Verification
The count is registered. A new value is due one rising edge after the inputs that call for it, and the bench drives inputs on falling edges and samples on the following falling edge. The carry output and the immediate preset are combinational. The bench samples them one time unit after the inputs change, before any clock edge can intervene. The cascade checks run a two-stage chain for more than a full wrap of the pair and compare the combined value with the edge count at every falling edge.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int  CNT_W    = 4;
    localparam int  BIN_LAST = (1 << CNT_W) - 1;
    localparam int  DEC_LAST = 9;

    typedef logic [CNT_W-1:0] nib_t;

    typedef enum logic { RNG_DEC = 1'b0, RNG_BIN = 1'b1 } range_e;
    typedef enum logic { DIR_DOWN = 1'b0, DIR_UP = 1'b1 } dir_e;

    typedef struct packed {
        range_e range;
        dir_e   dir;
    } ctl_t;

    // Highest state of the selected range; also the value a down-wrap lands on.
    function automatic nib_t range_top(range_e r);
        return (r == RNG_BIN) ? nib_t'(BIN_LAST) : nib_t'(DEC_LAST);
    endfunction

    // True on the last state before a wrap in the current direction.
    function automatic logic at_terminal(nib_t v, ctl_t c);
        if (c.dir == DIR_UP)
            return v == range_top(c.range);
        return v == '0;
    endfunction

    // Value after one counting step.
    function automatic nib_t step_value(nib_t v, ctl_t c);
        nib_t top;
        top = range_top(c.range);
        if (c.dir == DIR_UP)
            return (v >= top) ? '0 : nib_t'(v + 1'b1);
        return (v == '0) ? top : nib_t'(v - 1'b1);
    endfunction
endpackage

// File: rtl/bdc_next.sv
module bdc_next
    import bdc_pkg::*;
(
    input  nib_t cur,
    input  ctl_t ctl,
    output nib_t nxt
);
    timeunit 1ns;
    timeprecision 1ps;

    always_comb begin
        nxt = step_value(cur, ctl);
    end
endmodule

// File: rtl/bdc_carry.sv
module bdc_carry
    import bdc_pkg::*;
(
    input  nib_t cur,
    input  ctl_t ctl,
    input  logic cy_in_n,
    output logic cy_out_n
);
    timeunit 1ns;
    timeprecision 1ps;

    logic term;

    always_comb begin
        term     = at_terminal(cur, ctl);
        cy_out_n = ~(term & ~cy_in_n);
    end
endmodule

// File: rtl/bdc_reg.sv
module bdc_reg
    import bdc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load_en,
    input  nib_t load_val,
    input  logic advance_en,
    input  nib_t nxt,
    output nib_t cur
);
    timeunit 1ns;
    timeprecision 1ps;

    // Preset is asynchronous and outranks the synchronous reset.
    always_ff @(posedge clk or posedge load_en) begin
        if (load_en)
            cur <= load_val;
        else if (rst)
            cur <= '0;
        else if (advance_en)
            cur <= nxt;
    end
endmodule

// File: rtl/bd_updown_counter.sv
module bd_updown_counter
    import bdc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dir_up,
    input  logic             mode_bin,
    input  logic             cy_in_n,
    output logic [CNT_W-1:0] count,
    output logic             cy_out_n
);
    timeunit 1ns;
    timeprecision 1ps;

    ctl_t ctl;
    nib_t cur;
    nib_t nxt;

    always_comb begin
        ctl.range = mode_bin ? RNG_BIN : RNG_DEC;
        ctl.dir   = dir_up   ? DIR_UP  : DIR_DOWN;
    end

    bdc_next u_next (
        .cur (cur),
        .ctl (ctl),
        .nxt (nxt)
    );

    bdc_carry u_carry (
        .cur      (cur),
        .ctl      (ctl),
        .cy_in_n  (cy_in_n),
        .cy_out_n (cy_out_n)
    );

    bdc_reg u_reg (
        .clk        (clk),
        .rst        (rst),
        .load_en    (load_en),
        .load_val   (load_val),
        .advance_en (~cy_in_n),
        .nxt        (nxt),
        .cur        (cur)
    );

    assign count = cur;
endmodule

// File: rtl/bd_updown_counter_chk.sv
module bd_updown_counter_chk (
    input logic       clk,
    input logic       rst,
    input logic       load_en,
    input logic       dir_up,
    input logic       mode_bin,
    input logic       cy_in_n,
    input logic [3:0] count,
    input logic       cy_out_n
);
    timeunit 1ns;
    timeprecision 1ps;

    // R5: carry input high freezes the count across an edge
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!load_en && cy_in_n) |=> (load_en || count == $past(count)));

    // R1: binary up steps by one modulo 16
    a_r1_bin_up: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !cy_in_n && dir_up && mode_bin)
        |=> (load_en || count == 4'($past(count) + 4'd1)));

    // R4: decimal down from zero lands on nine
    a_r4_dec_down_zero: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !cy_in_n && !dir_up && !mode_bin && count == 4'd0)
        |=> (load_en || count == 4'd9));

    // R3: a legal decimal value stays legal while counting in decimal range
    a_r3_decade_legal: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !mode_bin && count <= 4'd9) |=> (load_en || count <= 4'd9));

    // R6: carry output can only be asserted while counting is enabled
    a_r6_carry_needs_enable: assert property (@(posedge clk) disable iff (rst)
        !cy_out_n |-> !cy_in_n);

    // R6: an asserted carry is followed by a wrap value
    a_r6_carry_wrap: assert property (@(posedge clk) disable iff (rst)
        (!cy_out_n && !load_en)
        |=> (load_en || count == 4'd0 || count == 4'd9 || count == 4'd15));
endmodule

bind bd_updown_counter bd_updown_counter_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .load_en  (load_en),
    .dir_up   (dir_up),
    .mode_bin (mode_bin),
    .cy_in_n  (cy_in_n),
    .count    (count),
    .cy_out_n (cy_out_n)
);

// File: tb/bd_updown_counter_bench.sv
module bd_updown_counter_bench;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst;
    logic       load_en;
    logic [3:0] load_val;
    logic [3:0] load_val_hi;
    logic       dir_up;
    logic       mode_bin;
    logic       cy_in_n;
    logic [3:0] count, count_hi;
    logic       cy_out_n, cy_out_hi_n;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    bd_updown_counter u_bd_updown_counter (
        .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val),
        .dir_up(dir_up), .mode_bin(mode_bin), .cy_in_n(cy_in_n),
        .count(count), .cy_out_n(cy_out_n)
    );

    bd_updown_counter u_bd_updown_counter_hi (
        .clk(clk), .rst(rst), .load_en(load_en), .load_val(load_val_hi),
        .dir_up(dir_up), .mode_bin(mode_bin), .cy_in_n(cy_out_n),
        .count(count_hi), .cy_out_n(cy_out_hi_n)
    );

    task automatic chk(string tag, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int top_of(bit b);
        return b ? 15 : 9;
    endfunction

    function automatic int model_next(int v, bit u, bit b);
        if (u) return (v >= top_of(b)) ? 0 : v + 1;
        return (v == 0) ? top_of(b) : v - 1;
    endfunction

    function automatic bit model_term(int v, bit u, bit b);
        return u ? (v == top_of(b)) : (v == 0);
    endfunction

    function automatic string tag_of(bit u, bit b);
        if (b) return u ? "R1" : "R2";
        return u ? "R3" : "R4";
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic preset(int v, int vh);
        load_val    = 4'(v);
        load_val_hi = 4'(vh);
        load_en     = 1'b1;
        #1;
        chk("R7", int'(count), v);
        tick();
        load_en = 1'b0;
    endtask

    initial begin
        rst = 1'b1; load_en = 1'b0; load_val = '0; load_val_hi = '0;
        dir_up = 1'b1; mode_bin = 1'b1; cy_in_n = 1'b1;
        tick(); tick();
        chk("R8", int'(count), 0);
        chk("R8", int'(count_hi), 0);
        chk("R6", int'(cy_out_n), 1);
        rst = 1'b0;

        // Sweep: both ranges, both directions, every start value
        for (int b = 0; b < 2; b++) begin
            for (int u = 0; u < 2; u++) begin
                for (int s = 0; s < 16; s++) begin
                    int exp;
                    mode_bin = b[0];
                    dir_up   = u[0];
                    cy_in_n  = 1'b1;
                    preset(s, 0);
                    cy_in_n = 1'b0;
                    exp = s;
                    for (int k = 0; k < 6; k++) begin
                        #1;
                        chk("R6", int'(cy_out_n),
                            model_term(exp, u[0], b[0]) ? 0 : 1);
                        tick();
                        exp = model_next(exp, u[0], b[0]);
                        chk(tag_of(u[0], b[0]), int'(count), exp);
                    end
                end
            end
        end

        // R5: inhibit holds the count, carry stays high at a terminal value
        mode_bin = 1'b1; dir_up = 1'b1; cy_in_n = 1'b1;
        preset(15, 0);
        for (int k = 0; k < 3; k++) begin
            tick();
            chk("R5", int'(count), 15);
            chk("R5", int'(cy_out_n), 1);
        end

        // R7: hold ignores counting, data change taken at next edge, resume after release
        cy_in_n = 1'b0; load_val = 4'd5; load_en = 1'b1;
        #1; chk("R7", int'(count), 5);
        tick(); chk("R7", int'(count), 5);
        load_val = 4'd11;
        #1; chk("R7", int'(count), 5);
        tick(); chk("R7", int'(count), 11);
        load_en = 1'b0;
        tick(); chk("R7", int'(count), 12);

        // R8: preset outranks reset, then reset clears
        rst = 1'b1; load_val = 4'd3; load_en = 1'b1;
        tick(); chk("R8", int'(count), 3);
        load_en = 1'b0;
        tick(); chk("R8", int'(count), 0);
        rst = 1'b0;

        // R10: run-time switching of direction and range
        mode_bin = 1'b0; dir_up = 1'b1; cy_in_n = 1'b1;
        preset(4, 0);
        cy_in_n = 1'b0;
        tick(); chk("R10", int'(count), 5);
        dir_up = 1'b0;
        tick(); chk("R10", int'(count), 4);
        mode_bin = 1'b1; cy_in_n = 1'b1;
        preset(0, 0);
        cy_in_n = 1'b0;
        tick(); chk("R10", int'(count), 15);
        mode_bin = 1'b0;
        tick(); chk("R10", int'(count), 14);

        // R9: two-stage chain, decimal up over a full wrap
        mode_bin = 1'b0; dir_up = 1'b1; cy_in_n = 1'b1;
        preset(0, 0);
        cy_in_n = 1'b0;
        for (int k = 1; k <= 125; k++) begin
            tick();
            chk("R9", int'(count_hi) * 10 + int'(count), k % 100);
        end

        // R9: two-stage chain, binary down through zero
        mode_bin = 1'b1; dir_up = 1'b0; cy_in_n = 1'b1;
        preset(0, 0);
        cy_in_n = 1'b0;
        for (int k = 1; k <= 40; k++) begin
            tick();
            chk("R9", int'(count_hi) * 16 + int'(count), (256 - k) % 256);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule